// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block drives an 8-bit NOR flash that runs its own program and erase algorithms. A host starts one operation with a single-cycle request: write one byte, erase a set of sectors, or erase the whole array. The sequencer then produces the unlock and command bus writes the device expects. Every write is framed by a write strobe whose setup, low and high phases are set in clock cycles. After the last command write it reads the device status at a programmable interval until the operation has finished.

Completion is detected by data-complement polling. While the device is busy, bit 7 of a read returns the inverse of the value being stored. The operation is complete once bit 7 equals the expected value: the programmed byte's bit 7 for a write, or 1 for an erase. If polling runs past a programmable cycle limit, the sequencer gives up, reports an error and leaves the bus quiet. A sector erase takes an 8-bit sector mask. The command for each selected sector follows the first without a new unlock, so one erase covers any combination of sectors.

Top module: `flash_cmd_seq`

## Requirements
- R1: Command code 0 (byte program) issues exactly four writes: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the data byte to the target address.
- R2: Command code 2 (chip erase) issues exactly six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h.
- R3: Command code 1 (sector erase) issues the first five writes of R2. It then writes 30h once per set bit of the sector mask, in ascending bit order, with no further unlock writes. The address is the sector number (mask bit index) in address bits 16:14 and zeros below.
- R4: Every write holds chip select low with write strobe high for T_SU cycles, then drives the strobe low for exactly T_WP cycles, then high for T_WPH cycles, before chip select is released.
- R5: Address and write data do not change while the write strobe is low, nor in the cycle it returns high.
- R6: After the last command write, status reads are separated by at least poll_gap_i idle bus cycles. done_o pulses for one cycle when a read's bit 7 equals the expected value (data bit 7 for a program, 1 for an erase), and busy_o is low from that cycle on.
- R7: If no matching read has arrived when tmo_lim_i polling cycles have elapsed, error_o pulses, busy_o falls, and no further bus cycle is started.
- R8: A sector erase with an all-zero mask, or command code 3, is rejected: error_o pulses the cycle after the request and no bus cycle is made.
- R9: A request arriving while busy_o is high is ignored.
- R10: During reset busy_o, done_o and error_o are low, chip select, write strobe and output enable are high, and the data drive enable is low.
- R11: While busy_o is low, chip select stays high and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle operation request, taken only when idle |
| cmd_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| addr_i | input | ADDR_W | Target byte address for a program |
| data_i | input | DATA_W | Byte to program |
| sec_mask_i | input | 2**SEC_W | Sectors to erase, bit i selects sector i |
| poll_gap_i | input | GAP_W | Minimum idle cycles before each status read |
| tmo_lim_i | input | TMO_W | Polling cycle limit |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| error_o | output | 1 | One-cycle pulse on rejection or timeout |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_wdata_o | output | DATA_W | Flash write data |
| fl_rdata_i | input | DATA_W | Flash read data |
| fl_drv_o | output | 1 | Enable for driving the flash data bus |
| fl_cs_no | output | 1 | Flash chip select, active low |
| fl_we_no | output | 1 | Flash write strobe, active low |
| fl_oe_no | output | 1 | Flash output enable, active low |

## Verification
Programs are tried with data whose bit 7 is both 0 and 1, so a sequencer that compares the wrong polarity would end at once or never. Sector erases use single-sector, sparse and full masks, plus random masks. These separate a correct ascending walk from one that skips, repeats or reorders sectors or that re-unlocks between them. A device model whose busy time never ends shows the timeout path. Empty masks, the reserved code and a request injected mid-operation cover the cases in which nothing may reach the bus.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2, OP_RSVD = 2'd3} op_e;
  typedef enum logic [2:0] {BUS_IDLE, BUS_SU, BUS_LOW, BUS_HI, BUS_RD} bus_st_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_WR, SQ_WR_WAIT, SQ_GAP, SQ_RD, SQ_RD_WAIT} sq_st_e;
  localparam logic [7:0]  CODE_KEY1  = 8'hAA;
  localparam logic [7:0]  CODE_KEY2  = 8'h55;
  localparam logic [7:0]  CODE_PROG  = 8'hA0;
  localparam logic [7:0]  CODE_ERASE = 8'h80;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;
  localparam logic [7:0]  CODE_SECT  = 8'h30;
  localparam logic [15:0] KEY_ADR1   = 16'h5555;
  localparam logic [15:0] KEY_ADR2   = 16'h2AAA;
endpackage

// File: rtl/flash_seq_cmd.sv
module flash_seq_cmd
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int SEC_W  = 3
) (
  input  op_e               op_i,
  input  logic [2:0]        step_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [DATA_W-1:0] tgt_data_i,
  input  logic [SEC_W-1:0]  sec_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);
  localparam int OFS_W = ADDR_W - SEC_W;
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(KEY_ADR1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(KEY_ADR2);

  always_comb begin
    addr_o = A1;
    data_o = DATA_W'(CODE_KEY1);
    last_o = 1'b0;
    if (op_i == OP_PROG) begin
      case (step_i)
        3'd0: ;
        3'd1: begin addr_o = A2; data_o = DATA_W'(CODE_KEY2); end
        3'd2: data_o = DATA_W'(CODE_PROG);
        default: begin addr_o = tgt_addr_i; data_o = tgt_data_i; last_o = 1'b1; end
      endcase
    end else begin
      case (step_i)
        3'd0: ;
        3'd1: begin addr_o = A2; data_o = DATA_W'(CODE_KEY2); end
        3'd2: data_o = DATA_W'(CODE_ERASE);
        3'd3: ;
        3'd4: begin addr_o = A2; data_o = DATA_W'(CODE_KEY2); end
        default: begin
          last_o = 1'b1;
          if (op_i == OP_CHIP) data_o = DATA_W'(CODE_CHIP);
          else begin
            addr_o = {sec_i, OFS_W'(0)};
            data_o = DATA_W'(CODE_SECT);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_bus.sv
module flash_seq_bus
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int T_SU   = 1,
  parameter int T_WP   = 4,
  parameter int T_WPH  = 2,
  parameter int T_RD   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_drv_o,
  output logic              bus_cs_no,
  output logic              bus_we_no,
  output logic              bus_oe_no
);
  localparam int T_A   = (T_SU > T_WP) ? T_SU : T_WP;
  localparam int T_B   = (T_WPH > T_RD) ? T_WPH : T_RD;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W = $clog2(T_MAX + 1);

  bus_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              ack_q;
  logic              last_cyc;

  assign last_cyc = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BUS_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= ((st_q == BUS_HI) || (st_q == BUS_RD)) && last_cyc;
      case (st_q)
        BUS_IDLE: begin
          if (wr_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            cnt_q   <= CNT_W'(T_SU - 1);
            st_q    <= BUS_SU;
          end else if (rd_i) begin
            addr_q <= addr_i;
            cnt_q  <= CNT_W'(T_RD - 1);
            st_q   <= BUS_RD;
          end
        end
        BUS_SU: begin
          if (last_cyc) begin cnt_q <= CNT_W'(T_WP - 1); st_q <= BUS_LOW; end
          else cnt_q <= cnt_q - 1'b1;
        end
        BUS_LOW: begin
          if (last_cyc) begin cnt_q <= CNT_W'(T_WPH - 1); st_q <= BUS_HI; end
          else cnt_q <= cnt_q - 1'b1;
        end
        BUS_HI: begin
          if (last_cyc) st_q <= BUS_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        BUS_RD: begin
          if (last_cyc) begin rdata_q <= bus_rdata_i; st_q <= BUS_IDLE; end
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= BUS_IDLE;
      endcase
    end
  end

  assign ack_o       = ack_q;
  assign rdata_o     = rdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign bus_cs_no   = (st_q == BUS_IDLE);
  assign bus_we_no   = (st_q != BUS_LOW);
  assign bus_oe_no   = (st_q != BUS_RD);
  assign bus_drv_o   = (st_q == BUS_SU) || (st_q == BUS_LOW) || (st_q == BUS_HI);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int SEC_W  = 3,
  parameter int T_SU   = 1,
  parameter int T_WP   = 4,
  parameter int T_WPH  = 2,
  parameter int T_RD   = 4,
  parameter int GAP_W  = 16,
  parameter int TMO_W  = 32,
  localparam int N_SEC = 1 << SEC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [N_SEC-1:0]  sec_mask_i,
  input  logic [GAP_W-1:0]  poll_gap_i,
  input  logic [TMO_W-1:0]  tmo_lim_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_wdata_o,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              fl_drv_o,
  output logic              fl_cs_no,
  output logic              fl_we_no,
  output logic              fl_oe_no
);
  sq_st_e            st_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [N_SEC-1:0]  mask_q, mask_nxt;
  logic [2:0]        step_q;
  logic              exp7_q, done_q, err_q;
  logic [GAP_W-1:0]  gap_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [SEC_W-1:0]  sec_cur;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data, rd_data;
  logic              cmd_last, bus_ack;
  op_e               req_op;

  assign req_op = op_e'(cmd_i);

  // lowest selected sector goes first
  always_comb begin
    sec_cur = '0;
    for (int i = N_SEC - 1; i >= 0; i--) begin
      if (mask_q[i]) sec_cur = SEC_W'(i);
    end
  end
  assign mask_nxt = mask_q & ~(N_SEC'(1) << sec_cur);

  flash_seq_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W)) u_cmd (
    .op_i(op_q), .step_i(step_q), .tgt_addr_i(addr_q), .tgt_data_i(data_q),
    .sec_i(sec_cur), .addr_o(cmd_addr), .data_o(cmd_data), .last_o(cmd_last)
  );

  flash_seq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_SU(T_SU), .T_WP(T_WP),
                  .T_WPH(T_WPH), .T_RD(T_RD)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(st_q == SQ_WR), .rd_i(st_q == SQ_RD),
    .addr_i((st_q == SQ_RD) ? addr_q : cmd_addr), .wdata_i(cmd_data),
    .ack_o(bus_ack), .rdata_o(rd_data),
    .bus_addr_o(fl_addr_o), .bus_wdata_o(fl_wdata_o), .bus_rdata_i(fl_rdata_i),
    .bus_drv_o(fl_drv_o), .bus_cs_no(fl_cs_no), .bus_we_no(fl_we_no), .bus_oe_no(fl_oe_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
      step_q <= '0;
      exp7_q <= 1'b0;
      gap_q  <= '0;
      tmo_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (req_i) begin
            if (req_op == OP_RSVD || (req_op == OP_SECT && sec_mask_i == '0)) begin
              err_q <= 1'b1;
            end else begin
              op_q   <= req_op;
              addr_q <= addr_i;
              data_q <= data_i;
              mask_q <= sec_mask_i;
              step_q <= '0;
              exp7_q <= (req_op == OP_PROG) ? data_i[DATA_W-1] : 1'b1;
              st_q   <= SQ_WR;
            end
          end
        end
        SQ_WR: st_q <= SQ_WR_WAIT;
        SQ_WR_WAIT: begin
          if (bus_ack) begin
            if (!cmd_last) begin
              step_q <= step_q + 1'b1;
              st_q   <= SQ_WR;
            end else if (op_q == OP_SECT && mask_nxt != '0) begin
              mask_q <= mask_nxt;
              st_q   <= SQ_WR;
            end else begin
              mask_q <= '0;
              gap_q  <= poll_gap_i;
              tmo_q  <= '0;
              st_q   <= SQ_GAP;
            end
          end
        end
        SQ_GAP: begin
          tmo_q <= tmo_q + 1'b1;
          if (tmo_q >= tmo_lim_i) begin
            err_q <= 1'b1;
            st_q  <= SQ_IDLE;
          end else if (gap_q == '0) st_q <= SQ_RD;
          else gap_q <= gap_q - 1'b1;
        end
        SQ_RD: begin
          tmo_q <= tmo_q + 1'b1;
          st_q  <= SQ_RD_WAIT;
        end
        SQ_RD_WAIT: begin
          tmo_q <= tmo_q + 1'b1;
          if (bus_ack) begin
            if (rd_data[DATA_W-1] == exp7_q) begin
              done_q <= 1'b1;
              st_q   <= SQ_IDLE;
            end else begin
              gap_q <= poll_gap_i;
              st_q  <= SQ_GAP;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != SQ_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int T_WP   = 4,
  parameter int GAP_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [GAP_W-1:0]  poll_gap_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [DATA_W-1:0] fl_wdata_o,
  input logic              fl_drv_o,
  input logic              fl_cs_no,
  input logic              fl_we_no,
  input logic              fl_oe_no
);
  logic [15:0]      low_cnt_q;
  logic [GAP_W:0]   gap_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      gap_cnt_q <= '0;
    end else begin
      if (!fl_we_no) low_cnt_q <= (low_cnt_q == 16'hFFFF) ? low_cnt_q : low_cnt_q + 1'b1;
      else low_cnt_q <= '0;
      if (!fl_cs_no) gap_cnt_q <= '0;
      else if (gap_cnt_q != '1) gap_cnt_q <= gap_cnt_q + 1'b1;
    end
  end

  assert_we_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> (low_cnt_q == 16'(T_WP)));

  assert_we_low_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> (!fl_cs_no && fl_oe_no && fl_drv_o));

  assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no || $rose(fl_we_no)) |-> ($stable(fl_addr_o) && $stable(fl_wdata_o)));

  assert_poll_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_oe_no) |-> (gap_cnt_q >= (GAP_W+1)'(poll_gap_i)));

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !error_o));

  assert_error_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !busy_o);

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (fl_cs_no && !fl_drv_o));
endmodule

bind flash_cmd_seq flash_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_WP(T_WP), .GAP_W(GAP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .poll_gap_i(poll_gap_i), .busy_o(busy_o), .done_o(done_o),
  .error_o(error_o), .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_drv_o(fl_drv_o),
  .fl_cs_no(fl_cs_no), .fl_we_no(fl_we_no), .fl_oe_no(fl_oe_no)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T_SU = 1, T_WP = 4, T_WPH = 2, T_RD = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req; logic [1:0] cmd; logic [16:0] addr; logic [7:0] data, mask;
  logic [15:0] gap; logic [31:0] tmo;
  logic busy, done, err, fdrv, fcs_n, fwe_n, foe_n;
  logic [16:0] fa; logic [7:0] fwd, frd;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.T_SU(T_SU), .T_WP(T_WP), .T_WPH(T_WPH), .T_RD(T_RD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .cmd_i(cmd), .addr_i(addr), .data_i(data),
    .sec_mask_i(mask), .poll_gap_i(gap), .tmo_lim_i(tmo), .busy_o(busy), .done_o(done),
    .error_o(err), .fl_addr_o(fa), .fl_wdata_o(fwd), .fl_rdata_i(frd), .fl_drv_o(fdrv),
    .fl_cs_no(fcs_n), .fl_we_no(fwe_n), .fl_oe_no(foe_n));

  // device model and bus monitor
  int mdl_lat = 50, mdl_cnt = 0;
  logic [7:0] mdl_exp = 8'hFF;
  bit armed = 0;
  logic [16:0] log_a [1024];
  logic [7:0]  log_d [1024];
  int log_n = 0, rd_n = 0, tbad = 0, cs_act = 0;
  int su_run = 0, lo_run = 0, hi_run = 0, phase = 0;
  logic foe_d = 1'b1;

  assign frd = (mdl_cnt != 0) ? {~mdl_exp[7], 7'h2A} : mdl_exp;

  always @(posedge clk) begin
    if (mdl_cnt > 0) mdl_cnt--;
    if (rst_ni) begin
      if (!fcs_n) cs_act++;
      if (!foe_n && foe_d) rd_n++;
      foe_d = foe_n;
      if (fcs_n) begin
        if (phase == 2 && hi_run != T_WPH) tbad++;
        phase = 0; su_run = 0;
      end else if (!foe_n) begin
      end else if (!fwe_n) begin
        if (phase == 0 && su_run != T_SU) tbad++;
        if (phase != 1) lo_run = 0;
        phase = 1; lo_run++;
      end else begin
        if (phase == 1) begin
          if (lo_run != T_WP) tbad++;
          phase = 2; hi_run = 0;
          if (log_n < 1024) begin log_a[log_n] = fa; log_d[log_n] = fwd; end
          log_n++;
          if (armed) begin mdl_exp = fwd; mdl_cnt = mdl_lat; armed = 0; end
          else if (fwd == 8'hA0 && fa == 17'h05555) armed = 1;
          else if (fwd == 8'h30 || fwd == 8'h10) begin mdl_exp = 8'hFF; mdl_cnt = mdl_lat; end
        end
        if (phase == 0) su_run++; else hi_run++;
      end
    end
  end

  logic [16:0] exp_a [16];
  logic [7:0]  exp_d [16];
  int exp_n;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic push(logic [16:0] a, logic [7:0] d);
    exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic build_exp(logic [1:0] op, logic [16:0] a, logic [7:0] d, logic [7:0] m);
    exp_n = 0;
    push(17'h05555, 8'hAA); push(17'h02AAA, 8'h55);
    if (op == 2'd0) begin
      push(17'h05555, 8'hA0); push(a, d);
    end else begin
      push(17'h05555, 8'h80); push(17'h05555, 8'hAA); push(17'h02AAA, 8'h55);
      if (op == 2'd2) push(17'h05555, 8'h10);
      else for (int s = 0; s < 8; s++) if (m[s]) push({s[2:0], 14'h0}, 8'h30);
    end
  endtask

  task automatic do_op(logic [1:0] op, logic [16:0] a, logic [7:0] d, logic [7:0] m, int lat,
                       logic [15:0] gv, logic [31:0] tv, bit inject,
                       output bit gd, output bit ge, output int cyc, output int base, output int rd0);
    @(negedge clk);
    mdl_lat = lat; gap = gv; tmo = tv; base = log_n; rd0 = rd_n;
    req = 1; cmd = op; addr = a; data = d; mask = m;
    @(negedge clk);
    req = 0; cyc = 1; gd = 0; ge = 0;
    while (!gd && !ge && cyc < 60000) begin
      gd = done; ge = err;
      if (!gd && !ge) begin
        if (inject && cyc == 4) begin req = 1; cmd = 2'd2; mask = 8'hFF; data = ~d; end
        else req = 0;
        @(negedge clk); cyc++;
      end
    end
    req = 0;
  endtask

  task automatic run_ok(logic [1:0] op, logic [16:0] a, logic [7:0] d, logic [7:0] m, int lat, bit inject);
    bit gd, ge; int cyc, base, rd0, n, bad_i, after;
    string tag;
    tag = (op == 2'd0) ? "R1" : (op == 2'd2) ? "R2" : "R3";
    do_op(op, a, d, m, lat, 16'd3, 32'd50000, inject, gd, ge, cyc, base, rd0);
    chk(gd && !ge, "R6", "done seen", {gd, ge}, 2'b10);
    chk(mdl_cnt == 0, "R6", "device idle at done", mdl_cnt, 0);
    chk(rd_n > rd0, "R6", "status reads", rd_n - rd0, 1);
    chk(!busy, "R6", "busy after done", busy, 0);
    build_exp(op, a, d, m);
    n = log_n - base; bad_i = -1;
    for (int i = 0; i < exp_n && i < n; i++)
      if (bad_i < 0 && (log_a[base+i] != exp_a[i] || log_d[base+i] != exp_d[i])) bad_i = i;
    chk(n == exp_n, tag, "write count", n, exp_n);
    if (bad_i >= 0) chk(0, tag, "write addr/data", {log_a[base+bad_i], log_d[base+bad_i]}, {exp_a[bad_i], exp_d[bad_i]});
    else chk(1, tag, "write sequence", 0, 0);
    after = cs_act;
    repeat (20) @(negedge clk);
    chk(cs_act == after && log_n == base + exp_n, inject ? "R9" : "R11", "bus quiet after end", cs_act - after, 0);
  endtask

  task automatic run_reject(logic [1:0] op);
    bit gd, ge; int cyc, base, rd0, after;
    after = cs_act;
    do_op(op, 17'h1F00, 8'h11, 8'h00, 20, 16'd3, 32'd50000, 0, gd, ge, cyc, base, rd0);
    chk(ge && !gd && cyc == 1, "R8", "reject error pulse", {gd, ge, 8'(cyc)}, {2'b01, 8'd1});
    repeat (10) @(negedge clk);
    chk(cs_act == after && !busy, "R8", "no bus cycle on reject", cs_act - after, 0);
  endtask

  initial begin
    bit gd, ge; int cyc, base, rd0, after;
    void'($urandom(32'h5EED1234));
    req = 0; cmd = 0; addr = 0; data = 0; mask = 0; gap = 3; tmo = 50000;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err, "R10", "status in reset", {busy, done, err}, 0);
    chk(fcs_n && fwe_n && foe_n && !fdrv, "R10", "bus pins in reset", {fcs_n, fwe_n, foe_n, fdrv}, 4'b1110);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    run_ok(2'd0, 17'h1ABCD, 8'h80, 8'h00, 40, 0);
    run_ok(2'd0, 17'h00001, 8'h35, 8'h00, 40, 1);
    run_ok(2'd0, 17'h15555, 8'hA0, 8'h00, 15, 0);
    run_ok(2'd2, 17'h00000, 8'h00, 8'h00, 100, 0);
    run_ok(2'd1, 17'h00000, 8'h00, 8'h81, 30, 0);
    run_ok(2'd1, 17'h00000, 8'h00, 8'h01, 30, 0);
    run_ok(2'd1, 17'h00000, 8'h00, 8'hFF, 60, 0);
    run_reject(2'd1);
    run_reject(2'd3);

    // timeout: device never finishes
    do_op(2'd0, 17'h02020, 8'h7F, 8'h00, 1000000, 16'd5, 32'd300, 0, gd, ge, cyc, base, rd0);
    chk(ge && !gd, "R7", "timeout error", {gd, ge}, 2'b01);
    chk(cyc >= 300, "R7", "timeout not early", cyc, 300);
    after = cs_act;
    repeat (100) @(negedge clk);
    chk(cs_act == after && !busy, "R7", "bus idle after timeout", cs_act - after, 0);

    for (int k = 0; k < 20; k++) begin
      logic [1:0] op; logic [7:0] m;
      op = 2'($urandom_range(0, 2));
      m  = 8'($urandom_range(1, 255));
      run_ok(op, 17'($urandom), 8'($urandom), m, $urandom_range(10, 200), 0);
    end

    chk(tbad == 0, "R4", "strobe phase lengths", tbad, 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule